// File: doc/BRIEF.md
# Prime Implicant Generator

This engine takes a single-output Boolean function of four inputs, given as the set of input codes for which the function is 1. It works out every prime implicant of that function by repeated adjacency merging, in the manner of the tabulation method. A start pulse loads the on-set. The engine then runs one merging pass per possible implicant size. In each pass, every implicant with a given number of eliminated inputs is tested against partners that differ from it in exactly one remaining input position. Implicants that never find a partner are kept as primes.

Each implicant is held as a value and a dash mask. A set mask bit means that input has been eliminated. When merging ends, `done` rises and the primes leave one per beat on a valid/ready stream. Duplicates that arise from different merge pairs collapse onto a single entry, so each prime leaves exactly once. Selecting essential primes, don't-care handling and any textual form of the result are left to the consumer.

Top module: `prime_impl_gen`

## Requirements
- R1: After reset, `done` and `outValid` are both low.
- R2: Bit i of `onSet` is 1 exactly when the function is 1 for input code i, with input code bit 3 as the most significant input. A beat carries `outValue` and `outMask`. A set bit in `outMask` marks that input as eliminated, and `outValue` is zero in every masked position.
- R3: Every beat is a prime implicant of the on-set. All input codes it covers are in the on-set, and widening it by dropping any one remaining literal would cover an off-set code.
- R4: Every prime implicant of the on-set is emitted, and each one exactly once.
- R5: Beats leave in strictly ascending order of the 8-bit key {outMask, outValue}.
- R6: An all-zero on-set raises `done` and produces no beat.
- R7: An all-ones on-set produces exactly one beat, with value 0 and mask 4'b1111.
- R8: While `outValid` is high and `outReady` is low, the next cycle still has `outValid` high and the same value and mask.
- R9: A `start` that arrives while merging or streaming is in progress has no effect. The result of the run already under way is emitted unchanged, and the stray pulse does not begin a new run.
- R10: `done` falls in the cycle after an accepted `start`. It stays low while merging, rises when the first beat may be offered, and remains high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current `onSet` (taken only when idle) |
| onSet | input | 16 | On-set mask, bit i for input code i |
| done | output | 1 | Merging finished; result available or already drained |
| outValid | output | 1 | A prime implicant is offered |
| outReady | input | 1 | Consumer takes the offered beat at this edge |
| outValue | output | 4 | Literal values of the offered implicant |
| outMask | output | 4 | Eliminated-input mask of the offered implicant |

## Verification
The stimulus covers several kinds of on-set. Isolated minterms and a parity function admit no merge at all, so they show whether unmerged terms are kept. Small on-sets with overlapping pairs show whether terms that take part in several pairs are marked correctly. A four-input function whose primes share minterms in many ways shows whether duplicate cubes are collapsed and larger cubes are built over several passes. The empty and full on-sets mark the two extremes: no output at all, and one cube spanning every input. Every beat is compared against a prime test computed from the definition. Back-pressure on the stream and stray start pulses during merging and during streaming show that the result survives stalls and interference.

// File: rtl/prime_impl_pkg.sv
package prime_impl_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // clear tables and load the on-set
    logic merge;  // process the entry under the scan index
  } ctrlStrobes_t;

endpackage

// File: rtl/pig_control.sv
module pig_control
  import prime_impl_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    curPrime,
  input  logic                    outReady,
  output ctrlStrobes_t            strobes,
  output logic [2*NUM_VARS-1:0]   idx,
  output logic [$clog2(NUM_VARS+1)-1:0] pass,
  output logic                    done,
  output logic                    outValid
);
  localparam int KEY_W  = 2 * NUM_VARS;
  localparam int PASS_W = $clog2(NUM_VARS + 1);
  localparam logic [KEY_W-1:0]  KEY_LAST  = {KEY_W{1'b1}};
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(NUM_VARS - 1);

  typedef enum logic [1:0] {S_IDLE, S_MERGE, S_EMIT} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      pass  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_MERGE;
            idx   <= '0;
            pass  <= '0;
            done  <= 1'b0;
          end
        end
        S_MERGE: begin
          idx <= idx + 1'b1;
          if (idx == KEY_LAST) begin
            if (pass == PASS_LAST) begin
              state <= S_EMIT;
              done  <= 1'b1;
            end else begin
              pass <= pass + 1'b1;
            end
          end
        end
        S_EMIT: begin
          if (!curPrime || outReady) begin
            idx <= idx + 1'b1;
            if (idx == KEY_LAST) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load  = (state == S_IDLE) && start;
    strobes.merge = (state == S_MERGE);
    outValid      = (state == S_EMIT) && curPrime;
  end

  // R8: a stalled beat stays offered with the same key
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(idx)));

  // R9: streaming never falls straight back into merging
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EMIT) |=> (state != S_MERGE));

  // R10: done is high whenever beats may be offered, low while merging
  p_done_in_emit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EMIT) |-> done);
  p_done_low_merge_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MERGE) |-> !done);

endmodule

// File: rtl/pig_datapath.sv
module pig_datapath
  import prime_impl_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [(1<<NUM_VARS)-1:0]      onSet,
  input  logic [2*NUM_VARS-1:0]         idx,
  input  logic [$clog2(NUM_VARS+1)-1:0] pass,
  output logic                          curPrime
);
  localparam int NUM_TERMS = 1 << NUM_VARS;
  localparam int KEY_W     = 2 * NUM_VARS;
  localparam int NUM_KEYS  = 1 << KEY_W;

  // Tables indexed by key = {mask, value}
  logic [NUM_KEYS-1:0] present;
  logic [NUM_KEYS-1:0] combined;

  logic [NUM_VARS-1:0] curValue, curMask;
  assign curValue = idx[NUM_VARS-1:0];
  assign curMask  = idx[KEY_W-1:NUM_VARS];

  logic inPass;
  assign inPass = strobes.merge && present[idx] &&
                  ($countones(curMask) == int'(pass));

  logic [KEY_W-1:0]    partnerKey [NUM_VARS];
  logic [KEY_W-1:0]    mergedKey  [NUM_VARS];
  logic [NUM_VARS-1:0] canMerge;

  for (genvar b = 0; b < NUM_VARS; b++) begin : g_bit
    localparam logic [NUM_VARS-1:0] BIT = NUM_VARS'(1) << b;
    assign partnerKey[b] = {curMask, curValue | BIT};
    assign mergedKey[b]  = {curMask | BIT, curValue};
    assign canMerge[b]   = inPass && !curValue[b] && !curMask[b] &&
                           present[partnerKey[b]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      present  <= '0;
      combined <= '0;
    end else if (strobes.load) begin
      present  <= NUM_KEYS'(onSet);
      combined <= '0;
    end else begin
      for (int b = 0; b < NUM_VARS; b++) begin
        if (canMerge[b]) begin
          present[mergedKey[b]]   <= 1'b1;
          combined[idx]           <= 1'b1;
          combined[partnerKey[b]] <= 1'b1;
        end
      end
    end
  end

  assign curPrime = present[idx] && !combined[idx];

  // R2: a stored implicant never has a literal set under its mask
  p_no_stray_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    present[idx] |-> ((curValue & curMask) == '0));

  // R2: a load places exactly the on-set in the single-minterm entries
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (present[NUM_TERMS-1:0] == $past(onSet)) && (combined == '0));

endmodule

// File: rtl/prime_impl_gen.sv
module prime_impl_gen
  import prime_impl_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [(1<<NUM_VARS)-1:0]   onSet,
  output logic                       done,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [NUM_VARS-1:0]        outValue,
  output logic [NUM_VARS-1:0]        outMask
);
  localparam int KEY_W  = 2 * NUM_VARS;
  localparam int PASS_W = $clog2(NUM_VARS + 1);

  ctrlStrobes_t      strobes;
  logic [KEY_W-1:0]  idx;
  logic [PASS_W-1:0] pass;
  logic              curPrime;

  pig_control #(.NUM_VARS(NUM_VARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .curPrime(curPrime),
    .outReady(outReady), .strobes(strobes), .idx(idx), .pass(pass),
    .done(done), .outValid(outValid)
  );

  pig_datapath #(.NUM_VARS(NUM_VARS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .onSet(onSet),
    .idx(idx), .pass(pass), .curPrime(curPrime)
  );

  assign outValue = idx[NUM_VARS-1:0];
  assign outMask  = idx[KEY_W-1:NUM_VARS];

endmodule

// File: tb/tb_prime_impl_gen.sv
`timescale 1ns/1ps
module tb_prime_impl_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] onSet = '0;
  logic outReady = 1'b0;
  logic done, outValid;
  logic [3:0] outValue, outMask;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  prime_impl_gen dut (
    .clk(clk), .rstN(rstN), .start(start), .onSet(onSet), .done(done),
    .outValid(outValid), .outReady(outReady), .outValue(outValue), .outMask(outMask)
  );

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference, from the definition of a prime implicant
  function automatic bit covers(logic [15:0] s, int v, int m);
    for (int t = 0; t < 16; t++)
      if (((t & ~m) & 15) == v && !s[t]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit isPrime(logic [15:0] s, int v, int m);
    if ((v & m) != 0) return 1'b0;
    if (!covers(s, v, m)) return 1'b0;
    for (int b = 0; b < 4; b++)
      if (!m[b] && covers(s, v & ~(1 << b), m | (1 << b))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int refCount(logic [15:0] s);
    int n = 0;
    for (int m = 0; m < 16; m++)
      for (int v = 0; v < 16; v++)
        if (isPrime(s, v, m)) n++;
    return n;
  endfunction

  // {on-set, expected number of primes}
  localparam int NV = 9;
  localparam logic [23:0] VECS [NV] = '{
    {16'h00C1, 8'd2},   // {0,6,7}
    {16'h00D1, 8'd3},   // {0,4,6,7}
    {16'hC1C1, 8'd2},   // {0,6,7,8,14,15}
    {16'h6996, 8'd8},   // odd parity, nothing merges
    {16'h0020, 8'd1},   // single minterm 5
    {16'h00FF, 8'd1},   // top input low
    {16'h47E7, 8'd6},   // overlapping primes
    {16'h0000, 8'd0},   // empty
    {16'hFFFF, 8'd1}    // full
  };

  // Start a run, check done falls, wait for done; optionally poke start mid-merge
  task automatic launch(input logic [15:0] s, input bit pokeMerge);
    @(negedge clk);
    onSet = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 done low after start", done, 0);
    for (int i = 0; i < 3000 && !done; i++) begin
      if (pokeMerge && i == 300) begin
        onSet = 16'hFFFF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (i == 500) check(done == 1'b0, "R10 done low while merging", done, 0);
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R10 done rises after merging", done, 1);
  endtask

  // Drain the stream and compare with the reference for refSet
  task automatic drain(input logic [15:0] refSet, input int expCount, input bit pokeEmit);
    int count = 0;
    int lastKey = -1;
    bit stalled = 1'b0;
    logic [3:0] heldV = '0, heldM = '0;
    for (int c = 0; c < 700; c++) begin
      outReady = (c % 3) != 1;
      if (stalled)
        check(outValid && outValue == heldV && outMask == heldM,
              "R8 beat held under back-pressure", {outMask, outValue}, {heldM, heldV});
      if (pokeEmit && count == 1) begin
        onSet = 16'hFFFF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (outValid && outReady) begin
        check(isPrime(refSet, int'(outValue), int'(outMask)), "R3 beat is prime",
              {outMask, outValue}, 1);
        check(int'({outMask, outValue}) > lastKey, "R5 ascending key order",
              {outMask, outValue}, lastKey + 1);
        check((outValue & outMask) == 4'd0, "R2 value clear under mask",
              outValue & outMask, 0);
        lastKey = int'({outMask, outValue});
        count++;
      end
      stalled = outValid && !outReady;
      heldV = outValue; heldM = outMask;
      @(negedge clk);
    end
    start = 1'b0;
    outReady = 1'b0;
    check(count == expCount, "R4 number of primes", count, expCount);
    check(count == refCount(refSet), "R4 all primes present once", count, refCount(refSet));
    check(done == 1'b1 && outValid == 1'b0, "R10 done held after drain", {done, outValid}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done low in reset", done, 0);
    check(outValid == 1'b0, "R1 valid low in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && outValid == 1'b0, "R1 idle after reset", {done, outValid}, 0);

    for (int k = 0; k < NV; k++) begin
      launch(VECS[k][23:8], 1'b0);
      drain(VECS[k][23:8], int'(VECS[k][7:0]), 1'b0);
    end

    // R6: empty on-set gives done and no beats
    launch(16'h0000, 1'b0);
    check(outValid == 1'b0, "R6 no beat for empty on-set", outValid, 0);
    drain(16'h0000, 0, 1'b0);

    // R7: full on-set gives the single all-dash cube
    launch(16'hFFFF, 1'b0);
    for (int c = 0; c < 300 && !outValid; c++) @(negedge clk);
    check(outValid && outValue == 4'd0 && outMask == 4'hF, "R7 full cube",
          {outMask, outValue}, 8'hF0);
    drain(16'hFFFF, 1, 1'b0);

    // R9: stray starts while merging and while streaming are ignored
    launch(16'h47E7, 1'b1);
    drain(16'h47E7, 6, 1'b1);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R9 no new run from stray start", done, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule